// File: doc/BRIEF.md
# Neighbor Link Reliability Tracker

This block keeps the reliability status of one neighbor entry. A link is not used as soon as it is seen. It first serves a probation interval, then has to pass an explicit link test, and only after that is it declared usable. While a link is in use, its metric is compared at each interval against a lower retention threshold. Because the join and retention thresholds are separate, the decision has hysteresis. A link whose metric falls under the retention threshold is not dropped at once: it is sent back to testing.

Management messages enter on a single valid/code/metric port. The block keeps the most recent metric for the entry. An internal down-counter, reloaded from a programmable period, paces every state. Whenever the entry changes state, the block emits a one-cycle table-update command. When the entry enters testing, it also emits a one-cycle request for a link test. To serve a neighbor table, one instance is placed for each entry.

States and transitions. `link_state` encodes Idle as 0, Probation as 1, Testing as 2 and Live as 3. The transitions are:
- **join**: Idle to Probation.
- **promote**: Probation to Testing.
- **reject**: Probation to Idle.
- **pass**: Testing to Live.
- **fail**: Testing to Idle.
- **refresh**: Live to Live.
- **retest**: Live to Testing.

Top module: `link_rel_fsm`

## Requirements
- R1: While reset is held, and in the first cycle after it, the state is Idle and neither pulse output is high. States are encoded Idle=0, Probation=1, Testing=2, Live=3.
- R2: In Idle, a valid message with code 0 (join) moves the entry to Probation and stores `msg_metric`. In the same edge it pulses update command 0 (join).
- R3: In Probation, Testing or Live, a valid message with code 1 (metric) stores `msg_metric`, keeps the state and pulses update command 1.
- R4: The interval counter loads `tmo_period` P on every state change and on every expiry. It then counts down to zero, and the timeout acts in the cycle in which it is zero. A state left only by timeout is therefore left P+1 cycles after it was entered.
- R5: In Probation, on timeout with stored metric >= `add_thresh`, the entry moves to Testing. It pulses `lt_req` and update command 2 (test).
- R6: In Probation, on timeout with stored metric < `add_thresh`, the entry returns to Idle and pulses update command 5 (clear).
- R7: In Testing, a valid code-2 (pass) message moves the entry to Live with update command 3. A timeout instead moves it to Idle with update command 4 (drop). If a pass and a timeout arrive together, the timeout wins.
- R8: In Live, on timeout with stored metric >= `rmv_thresh`, the entry stays Live and pulses update command 3 (refresh).
- R9: In Live, on timeout with stored metric < `rmv_thresh`, the entry moves to Testing. It pulses `lt_req` and update command 2.
- R10: A timeout takes precedence over any message in the same cycle. The following messages change nothing and produce no pulse: join outside Idle, pass outside Testing, metric in Idle, and code 3.
- R11: `lt_req` and `upd_valid` are high for one cycle each. They rise on the same edge as the transition they report, and `lt_req` rises only together with entry into Testing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| msg_valid | input | 1 | Management message present this cycle |
| msg_code | input | 2 | 0 join, 1 metric, 2 pass, 3 reserved |
| msg_metric | input | MW | Metric carried by join/metric messages |
| add_thresh | input | MW | Minimum metric to leave probation |
| rmv_thresh | input | MW | Minimum metric to stay live |
| tmo_period | input | TW | Interval counter reload value |
| link_state | output | 2 | Current entry state |
| lt_req | output | 1 | One-cycle link-test request |
| upd_valid | output | 1 | One-cycle table-update strobe |
| upd_cmd | output | 3 | Update command code, valid with upd_valid |

## Verification
The bench drives a message in exactly the cycle the interval counter reaches zero, and in that cycle the timeout must win. A design that let a pass message win there would show the entry going Live instead of Idle. The bench also places metrics exactly at each threshold, where a design using a strict comparison would reject or retest a link that should be kept. It measures the dwell time in Probation against P+1, which catches a counter that is not reloaded on entry or that is off by one. Finally, it sends messages that are out of place for the current state, and a state machine that decoded them loosely would produce stray pulses or transitions.

// File: rtl/lr_pkg.sv
package lr_pkg;
    typedef enum logic [1:0] {
        LS_IDLE  = 2'd0,
        LS_PROBE = 2'd1,
        LS_TEST  = 2'd2,
        LS_LIVE  = 2'd3
    } lnk_state_t;

    typedef enum logic [1:0] {
        MC_JOIN   = 2'd0,
        MC_METRIC = 2'd1,
        MC_PASS   = 2'd2,
        MC_RSVD   = 2'd3
    } msg_code_t;

    typedef enum logic [2:0] {
        UC_JOIN   = 3'd0,
        UC_METRIC = 3'd1,
        UC_TEST   = 3'd2,
        UC_LIVE   = 3'd3,
        UC_DROP   = 3'd4,
        UC_CLEAR  = 3'd5
    } upd_cmd_t;
endpackage

// File: rtl/lr_timer.sv
module lr_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reload,
    input  logic [TW-1:0] period,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (reload)
            cnt_q <= period;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R4: without a reload, a zero count cannot appear out of a count above one
    a_r4_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload && cnt_q > 1) |=> !expired);
endmodule

// File: rtl/lr_cmp.sv
module lr_cmp #(
    parameter int MW = 8
) (
    input  logic [MW-1:0] metric,
    input  logic [MW-1:0] add_th,
    input  logic [MW-1:0] rmv_th,
    output logic          ge_add,
    output logic          ge_rmv
);
    assign ge_add = (metric >= add_th);
    assign ge_rmv = (metric >= rmv_th);
endmodule

// File: rtl/link_rel_fsm.sv
module link_rel_fsm
    import lr_pkg::*;
#(
    parameter int MW = 8,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          msg_valid,
    input  logic [1:0]    msg_code,
    input  logic [MW-1:0] msg_metric,
    input  logic [MW-1:0] add_thresh,
    input  logic [MW-1:0] rmv_thresh,
    input  logic [TW-1:0] tmo_period,
    output logic [1:0]    link_state,
    output logic          lt_req,
    output logic          upd_valid,
    output logic [2:0]    upd_cmd
);
    lnk_state_t    st_q, st_d;
    logic [MW-1:0] met_q, met_d;
    logic          req_d, uv_d;
    upd_cmd_t      uc_d;
    logic          tmo, ge_add, ge_rmv, reload;
    msg_code_t     code;

    assign code = msg_code_t'(msg_code);

    lr_cmp #(.MW(MW)) u_cmp (
        .metric (met_q),
        .add_th (add_thresh),
        .rmv_th (rmv_thresh),
        .ge_add (ge_add),
        .ge_rmv (ge_rmv)
    );

    assign reload = (st_d != st_q) || tmo;

    lr_timer #(.TW(TW)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (reload),
        .period  (tmo_period),
        .expired (tmo)
    );

    // next-state and transition decode
    always_comb begin
        st_d  = st_q;
        met_d = met_q;
        req_d = 1'b0;
        uv_d  = 1'b0;
        uc_d  = UC_JOIN;
        unique case (st_q)
            LS_IDLE: begin
                if (msg_valid && code == MC_JOIN) begin
                    st_d  = LS_PROBE;
                    met_d = msg_metric;
                    uv_d  = 1'b1;
                    uc_d  = UC_JOIN;
                end
            end
            LS_PROBE: begin
                if (tmo) begin
                    uv_d = 1'b1;
                    if (ge_add) begin
                        st_d  = LS_TEST;
                        req_d = 1'b1;
                        uc_d  = UC_TEST;
                    end else begin
                        st_d  = LS_IDLE;
                        met_d = '0;
                        uc_d  = UC_CLEAR;
                    end
                end else if (msg_valid && code == MC_METRIC) begin
                    met_d = msg_metric;
                    uv_d  = 1'b1;
                    uc_d  = UC_METRIC;
                end
            end
            LS_TEST: begin
                if (tmo) begin
                    st_d  = LS_IDLE;
                    met_d = '0;
                    uv_d  = 1'b1;
                    uc_d  = UC_DROP;
                end else if (msg_valid && code == MC_PASS) begin
                    st_d = LS_LIVE;
                    uv_d = 1'b1;
                    uc_d = UC_LIVE;
                end else if (msg_valid && code == MC_METRIC) begin
                    met_d = msg_metric;
                    uv_d  = 1'b1;
                    uc_d  = UC_METRIC;
                end
            end
            LS_LIVE: begin
                if (tmo) begin
                    uv_d = 1'b1;
                    if (ge_rmv) begin
                        uc_d = UC_LIVE;
                    end else begin
                        st_d  = LS_TEST;
                        req_d = 1'b1;
                        uc_d  = UC_TEST;
                    end
                end else if (msg_valid && code == MC_METRIC) begin
                    met_d = msg_metric;
                    uv_d  = 1'b1;
                    uc_d  = UC_METRIC;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= LS_IDLE;
            met_q <= '0;
        end else begin
            st_q  <= st_d;
            met_q <= met_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lt_req    <= 1'b0;
            upd_valid <= 1'b0;
            upd_cmd   <= 3'd0;
        end else begin
            lt_req    <= req_d;
            upd_valid <= uv_d;
            upd_cmd   <= uc_d;
        end
    end

    assign link_state = st_q;

    // R1: reset leaves Idle with quiet pulse outputs
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (link_state == 2'd0 && !lt_req && !upd_valid));

    // R11: a test request only accompanies arrival in Testing
    a_r11_req_into_test: assert property (@(posedge clk) disable iff (!rst_n)
        lt_req |-> (st_q == LS_TEST && upd_valid && upd_cmd == 3'd2));

    // R11: every state change is reported
    a_r11_change_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != $past(st_q)) |-> upd_valid);

    // R7: Live is reached only from Testing
    a_r7_live_via_test: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LS_LIVE && $past(st_q) != LS_LIVE) |-> $past(st_q) == LS_TEST);

    // R10: a pass outside Testing changes nothing
    a_r10_pass_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_code == 2'd2 && st_q != LS_TEST && !tmo)
        |=> (st_q == $past(st_q) && !upd_valid));
endmodule

// File: tb/tb_link_rel_fsm.sv
module tb_link_rel_fsm;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       msg_valid = 1'b0;
    logic [1:0] msg_code = 2'd0;
    logic [7:0] msg_metric = 8'd0;
    logic [7:0] add_thresh = 8'd100;
    logic [7:0] rmv_thresh = 8'd60;
    logic [7:0] tmo_period = 8'd3;
    logic [1:0] link_state;
    logic       lt_req, upd_valid;
    logic [2:0] upd_cmd;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    int m_st, m_met, m_cnt;

    always #2.5 clk = ~clk;

    link_rel_fsm #(.MW(8), .TW(8)) dut (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_code(msg_code),
        .msg_metric(msg_metric), .add_thresh(add_thresh), .rmv_thresh(rmv_thresh),
        .tmo_period(tmo_period), .link_state(link_state), .lt_req(lt_req),
        .upd_valid(upd_valid), .upd_cmd(upd_cmd)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // one cycle: drive, predict, compare
    task automatic cyc(input bit v, input int c, input int m);
        bit tmo, er, ev;
        int ns, nm, ec;
        string tag;
        @(negedge clk);
        msg_valid = v; msg_code = c[1:0]; msg_metric = m[7:0];
        tmo = (m_cnt == 0);
        ns = m_st; nm = m_met; er = 0; ev = 0; ec = 0; tag = "R11";
        if (tmo && m_st != 0) begin
            ev = 1;
            case (m_st)
                1: if (m_met >= add_thresh) begin ns = 2; er = 1; ec = 2; tag = "R5"; end
                   else begin ns = 0; nm = 0; ec = 5; tag = "R6"; end
                2: begin ns = 0; nm = 0; ec = 4; tag = (v && c == 2) ? "R10" : "R7"; end
                default: if (m_met >= rmv_thresh) begin ec = 3; tag = "R8"; end
                         else begin ns = 2; er = 1; ec = 2; tag = "R9"; end
            endcase
        end else if (v) begin
            if (m_st == 0 && c == 0) begin ns = 1; nm = m; ev = 1; ec = 0; tag = "R2"; end
            else if (m_st != 0 && c == 1) begin nm = m; ev = 1; ec = 1; tag = "R3"; end
            else if (m_st == 2 && c == 2) begin ns = 3; ev = 1; ec = 3; tag = "R7"; end
            else tag = "R10";
        end
        @(posedge clk); #1;
        check(link_state == ns[1:0], tag, "state", link_state, ns);
        check(lt_req == er, tag, "lt_req", lt_req, er);
        check(upd_valid == ev, tag, "upd_valid", upd_valid, ev);
        if (ev) check(upd_cmd == ec[2:0], tag, "upd_cmd", upd_cmd, ec);
        if (ns != m_st || tmo) m_cnt = tmo_period;
        else if (m_cnt != 0) m_cnt--;
        m_st = ns; m_met = nm;
    endtask

    task automatic idle_to_tmo();
        while (m_cnt != 0) cyc(0, 0, 0);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'h5eed_1234));
        m_st = 0; m_met = 0; m_cnt = 0;
        repeat (3) @(posedge clk);
        #1;
        check(link_state == 2'd0, "R1", "reset state", link_state, 0);
        check(!lt_req && !upd_valid, "R1", "reset pulses", {lt_req, upd_valid}, 0);
        @(negedge clk); rst_n = 1'b1;
        cyc(0, 0, 0);

        // R10: out-of-place messages in Idle
        cyc(1, 1, 200); cyc(1, 2, 0); cyc(1, 3, 0);
        // R2 then R4 dwell: join at exactly add threshold
        cyc(1, 0, 100);
        n = 0;
        while (link_state == 2'd1 && n < 50) begin cyc(0, 0, 0); n++; end
        check(n == 4, "R4", "probation dwell", n, 4);
        check(link_state == 2'd2, "R5", "promote at threshold", link_state, 2);
        cyc(1, 0, 0);           // R10 join ignored in Testing
        cyc(1, 2, 0);           // R7 pass
        cyc(1, 1, 60);          // R3 metric exactly at remove threshold
        idle_to_tmo(); cyc(0, 0, 0);   // R8 refresh
        check(link_state == 2'd3, "R8", "stays live", link_state, 3);
        cyc(1, 1, 59);          // R3
        idle_to_tmo(); cyc(0, 0, 0);   // R9 retest
        idle_to_tmo(); cyc(1, 2, 0);   // R7/R10 pass loses to timeout
        check(link_state == 2'd0, "R7", "timeout beats pass", link_state, 0);
        cyc(1, 0, 99);          // R2 join below add
        idle_to_tmo(); cyc(1, 1, 250); // R6 reject, metric msg discarded
        check(link_state == 2'd0, "R6", "reject", link_state, 0);
        // period zero
        tmo_period = 8'd0;
        cyc(1, 0, 150); cyc(0, 0, 0); cyc(1, 2, 0); cyc(0, 0, 0);

        // random phase
        for (int i = 0; i < 6000; i++) begin
            if (i % 500 == 0) begin
                int a, r;
                a = $urandom_range(255, 0);
                r = $urandom_range(a, 0);
                add_thresh = a[7:0]; rmv_thresh = r[7:0];
                tmo_period = 8'($urandom_range(6, 0));
            end
            cyc(($urandom_range(99, 0) < 35), $urandom_range(3, 0), $urandom_range(255, 0));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule